// File: doc/BRIEF.md
# Ten-Field Sequence Marker

This block follows the five-frame (ten-field) cadence of an NTSC-timed raster and inserts a short digital pulse burst on one chosen line in each field. The burst says where the current frame sits in the cadence, so that downstream equipment can phase 48 kHz audio to the video. Frame 1 of the cadence is the frame in which the 48 kHz sample grid meets the horizontal sync of line 4 exactly. The burst carries one pulse in that frame, and one more pulse in each later frame, up to five.

An existing sync timing generator supplies the raster position: a field flag, a line number counted across the whole frame, and a sample index within the line. The block returns a logic-level marker, which the sync path ORs or muxes into its waveform, together with the current frame index. An enable input turns insertion on and off, and the cadence keeps running while insertion is off. A restart input realigns the cadence at the next frame boundary.

Top module: `ten_field_marker`

## Requirements
- R1: While `rst_n` is low at a clock edge, `frame_idx` becomes 1 and `marker_out` becomes 0. This also applies when reset is applied in the middle of a run.
- R2: A frame start is a sample presented with `pos_field2`=0, `pos_line`=1 and `pos_sample`=0. At each frame start, `frame_idx` takes a new value one clock later: it adds one, or goes back to 1 when the old value was 5. At every other time `frame_idx` holds.
- R3: A high `seq_restart` in any cycle arms a restart. The next frame start then loads `frame_idx` with 1 and does not advance it. This also holds when `seq_restart` is high in the same cycle as the frame start. Until that frame start, `frame_idx` does not change.
- R4: The marker is one clock behind the position inputs. In field 1 (`pos_field2`=0) on line `MARK_LINE_F1` (15), `marker_out` first goes high for START_HI (24) clocks, starting with the sample at offset 0 from `BURST_START` (140). It then stays low for PULSE_LO (8) clocks.
- R5: After the start pulse and gap of a field-1 burst come exactly `frame_idx` pulses. Each pulse is PULSE_HI (8) clocks high followed by PULSE_LO (8) clocks low.
- R6: In field 2 (`pos_field2`=1) on line `MARK_LINE_F2` (278), the burst is the same start pulse and gap, followed by one field-2 pulse. That pulse is F2_PULSE_HI (16) clocks high and then PULSE_LO clocks low.
- R7: When `mark_en` is low at a burst start, `marker_out` stays low for that line. Frame starts still advance `frame_idx` while insertion is off.
- R8: `mark_en` is sampled only where a burst would start. If it drops once a burst is under way, the burst still runs to its end.
- R9: `marker_out` stays low on every other line. This includes line 15 with the field-2 flag set, line 278 in field 1, and the lines next to the marker lines.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel-rate clock |
| rst_n | input | 1 | Synchronous reset, active low |
| pos_field2 | input | 1 | 0 during field 1, 1 during field 2 |
| pos_line | input | LINE_W (10) | Line number within the frame, from 1 |
| pos_sample | input | SAMPLE_W (10) | Sample index within the line, from 0 |
| mark_en | input | 1 | Turns burst insertion on |
| seq_restart | input | 1 | Arms a realignment of the cadence to frame 1 |
| marker_out | output | 1 | Burst signal to merge into sync |
| frame_idx | output | 3 | Position in the five-frame cadence, 1 to 5 |

## Verification
The assertions assume that the position inputs come from a sane raster. Within a marker line, `pos_sample` counts up by one per clock. A frame start sample is never presented while a burst is still running. The burst window also lies inside the active part of the line, so a burst is never cut short by the next line.

The stimulus keeps to these limits while staying short. It presents frame starts as single isolated samples and sweeps each line under test contiguously from sample 0 to well past the end of the longest burst. It never presents a frame start in the middle of a sweep.

// File: rtl/tfm_pkg.sv
// Shared constants and types for the ten-field sequence marker.
// Assumes a five-frame cadence; the index width is derived from it.
package tfm_pkg;
    localparam int unsigned SEQ_FRAMES = 5;
    localparam int unsigned IDX_W      = $clog2(SEQ_FRAMES + 1);

    typedef logic [IDX_W-1:0] frame_idx_t;

    typedef enum logic [1:0] {
        BURST_IDLE  = 2'd0,
        BURST_START = 2'd1,
        BURST_GAP   = 2'd2,
        BURST_HIGH  = 2'd3
    } burst_state_e;
endpackage

// File: rtl/tfm_raster_decode.sv
// Decodes raster position into the two events the marker needs:
// the frame start (field 1, first line, sample 0) and the burst start
// (first burst sample on the marker line of either field).
// Assumes the line number counts across the whole frame.
module tfm_raster_decode #(
    parameter int unsigned LINE_W           = 10,
    parameter int unsigned SAMPLE_W         = 10,
    parameter int unsigned FRAME_FIRST_LINE = 1,
    parameter int unsigned MARK_LINE_F1     = 15,
    parameter int unsigned MARK_LINE_F2     = 278,
    parameter int unsigned BURST_START      = 140
) (
    input  logic                pos_field2,
    input  logic [LINE_W-1:0]   pos_line,
    input  logic [SAMPLE_W-1:0] pos_sample,
    output logic                frame_start,
    output logic                burst_trig,
    output logic                trig_field2
);
    localparam logic [LINE_W-1:0]   FIRST_L = LINE_W'(FRAME_FIRST_LINE);
    localparam logic [LINE_W-1:0]   LINE_F1 = LINE_W'(MARK_LINE_F1);
    localparam logic [LINE_W-1:0]   LINE_F2 = LINE_W'(MARK_LINE_F2);
    localparam logic [SAMPLE_W-1:0] B_START = SAMPLE_W'(BURST_START);

    logic at_burst_sample;
    logic on_f1_line;
    logic on_f2_line;

    // Event decode from the current position.
    always_comb begin
        at_burst_sample = (pos_sample == B_START);
        on_f1_line      = !pos_field2 && (pos_line == LINE_F1);
        on_f2_line      =  pos_field2 && (pos_line == LINE_F2);
        frame_start     = !pos_field2 && (pos_line == FIRST_L) && (pos_sample == '0);
        burst_trig      = at_burst_sample && (on_f1_line || on_f2_line);
        trig_field2     = on_f2_line;
    end
endmodule

// File: rtl/tfm_frame_seq.sv
// Five-frame cadence counter. Holds the index 1..5, advances on each
// frame start and wraps from 5 to 1. A restart request is remembered
// until the next frame start, which then loads 1 instead of advancing.
// Assumes frame_start is a single-cycle strobe.
module tfm_frame_seq
    import tfm_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       frame_start,
    input  logic       seq_restart,
    output frame_idx_t frame_idx
);
    localparam frame_idx_t IDX_ONE  = IDX_W'(1);
    localparam frame_idx_t IDX_LAST = IDX_W'(SEQ_FRAMES);

    logic restart_armed;
    logic restart_due;

    // A restart is due if one is armed or requested right now.
    always_comb restart_due = restart_armed || seq_restart;

    // Index update and restart bookkeeping.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            frame_idx     <= IDX_ONE;
            restart_armed <= 1'b0;
        end else if (frame_start) begin
            restart_armed <= 1'b0;
            if (restart_due || frame_idx == IDX_LAST)
                frame_idx <= IDX_ONE;
            else
                frame_idx <= frame_idx + IDX_ONE;
        end else if (seq_restart) begin
            restart_armed <= 1'b1;
        end
    end

    p_idx_legal_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_idx >= IDX_ONE) && (frame_idx <= IDX_LAST));

    p_advance_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_start && !restart_due && frame_idx != IDX_LAST)
        |=> frame_idx == $past(frame_idx) + IDX_ONE);

    p_wrap_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_start && !restart_due && frame_idx == IDX_LAST)
        |=> frame_idx == IDX_ONE);

    p_restart_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_start && restart_due) |=> frame_idx == IDX_ONE);

    p_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !frame_start |=> $stable(frame_idx));
endmodule

// File: rtl/tfm_burst_gen.sv
// Pulse burst sequencer. On a burst start with insertion enabled it
// plays a start pulse, a gap, then N pulses each followed by a gap.
// N is the frame index in field 1 and one in field 2. The field-2
// pulse has its own width. The marker is decoded from registered
// state, so it lags the position inputs by one clock.
// Assumes the burst ends before the next burst start can occur.
module tfm_burst_gen
    import tfm_pkg::*;
#(
    parameter int unsigned START_HI    = 24,
    parameter int unsigned PULSE_HI    = 8,
    parameter int unsigned F2_PULSE_HI = 16,
    parameter int unsigned PULSE_LO    = 8
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       burst_trig,
    input  logic       trig_field2,
    input  logic       mark_en,
    input  frame_idx_t frame_idx,
    output logic       marker
);
    localparam int unsigned MAX_AB = (START_HI > PULSE_HI) ? START_HI : PULSE_HI;
    localparam int unsigned MAX_CD = (F2_PULSE_HI > PULSE_LO) ? F2_PULSE_HI : PULSE_LO;
    localparam int unsigned MAX_W  = (MAX_AB > MAX_CD) ? MAX_AB : MAX_CD;
    localparam int unsigned CNT_W  = $clog2(MAX_W + 1);

    localparam logic [CNT_W-1:0] START_LD = CNT_W'(START_HI - 1);
    localparam logic [CNT_W-1:0] LO_LD    = CNT_W'(PULSE_LO - 1);
    localparam logic [CNT_W-1:0] HI_LD    = CNT_W'(PULSE_HI - 1);
    localparam logic [CNT_W-1:0] F2_LD    = CNT_W'(F2_PULSE_HI - 1);

    burst_state_e     state;
    logic [CNT_W-1:0] seg_cnt;
    frame_idx_t       pulses_left;
    logic             in_field2;
    logic             seg_done;

    // Segment end flag from the down-counter.
    always_comb seg_done = (seg_cnt == '0);

    // Burst state machine with segment counter and pulse budget.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state       <= BURST_IDLE;
            seg_cnt     <= '0;
            pulses_left <= '0;
            in_field2   <= 1'b0;
        end else begin
            unique case (state)
                BURST_IDLE: begin
                    if (burst_trig && mark_en) begin
                        state       <= BURST_START;
                        seg_cnt     <= START_LD;
                        in_field2   <= trig_field2;
                        pulses_left <= trig_field2 ? IDX_W'(1) : frame_idx;
                    end
                end
                BURST_START: begin
                    if (seg_done) begin
                        state   <= BURST_GAP;
                        seg_cnt <= LO_LD;
                    end else begin
                        seg_cnt <= seg_cnt - 1'b1;
                    end
                end
                BURST_GAP: begin
                    if (!seg_done) begin
                        seg_cnt <= seg_cnt - 1'b1;
                    end else if (pulses_left == '0) begin
                        state <= BURST_IDLE;
                    end else begin
                        state       <= BURST_HIGH;
                        seg_cnt     <= in_field2 ? F2_LD : HI_LD;
                        pulses_left <= pulses_left - 1'b1;
                    end
                end
                BURST_HIGH: begin
                    if (seg_done) begin
                        state   <= BURST_GAP;
                        seg_cnt <= LO_LD;
                    end else begin
                        seg_cnt <= seg_cnt - 1'b1;
                    end
                end
                default: state <= BURST_IDLE;
            endcase
        end
    end

    // Marker is high in the start pulse and in every counted pulse.
    always_comb marker = (state == BURST_START) || (state == BURST_HIGH);

    p_start_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (state == BURST_IDLE && burst_trig && mark_en) |=> marker);

    p_disabled_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (state == BURST_IDLE && burst_trig && !mark_en) |=> !marker);

    p_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (state == BURST_IDLE && !burst_trig) |=> !marker);

    p_budget_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (state == BURST_HIGH) |-> (pulses_left < IDX_W'(SEQ_FRAMES)));

    p_runs_on_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (state == BURST_START && !seg_done) |=> (state == BURST_START));
endmodule

// File: rtl/ten_field_marker.sv
// Ten-field sequence marker top. Decodes raster position, keeps the
// five-frame cadence index and drives the pulse burst on the marker
// lines of both fields. Assumes the whole burst lies inside the active
// part of the line and that the position comes from a sync generator.
module ten_field_marker #(
    parameter int unsigned LINE_W           = 10,
    parameter int unsigned SAMPLE_W         = 10,
    parameter int unsigned FRAME_FIRST_LINE = 1,
    parameter int unsigned MARK_LINE_F1     = 15,
    parameter int unsigned MARK_LINE_F2     = 278,
    parameter int unsigned BURST_START      = 140,
    parameter int unsigned START_HI         = 24,
    parameter int unsigned PULSE_HI         = 8,
    parameter int unsigned F2_PULSE_HI      = 16,
    parameter int unsigned PULSE_LO         = 8
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         pos_field2,
    input  logic [LINE_W-1:0]            pos_line,
    input  logic [SAMPLE_W-1:0]          pos_sample,
    input  logic                         mark_en,
    input  logic                         seq_restart,
    output logic                         marker_out,
    output logic [tfm_pkg::IDX_W-1:0]    frame_idx
);
    logic frame_start;
    logic burst_trig;
    logic trig_field2;

    tfm_raster_decode #(
        .LINE_W           (LINE_W),
        .SAMPLE_W         (SAMPLE_W),
        .FRAME_FIRST_LINE (FRAME_FIRST_LINE),
        .MARK_LINE_F1     (MARK_LINE_F1),
        .MARK_LINE_F2     (MARK_LINE_F2),
        .BURST_START      (BURST_START)
    ) u_decode (
        .pos_field2  (pos_field2),
        .pos_line    (pos_line),
        .pos_sample  (pos_sample),
        .frame_start (frame_start),
        .burst_trig  (burst_trig),
        .trig_field2 (trig_field2)
    );

    tfm_frame_seq u_seq (
        .clk         (clk),
        .rst_n       (rst_n),
        .frame_start (frame_start),
        .seq_restart (seq_restart),
        .frame_idx   (frame_idx)
    );

    tfm_burst_gen #(
        .START_HI    (START_HI),
        .PULSE_HI    (PULSE_HI),
        .F2_PULSE_HI (F2_PULSE_HI),
        .PULSE_LO    (PULSE_LO)
    ) u_burst (
        .clk         (clk),
        .rst_n       (rst_n),
        .burst_trig  (burst_trig),
        .trig_field2 (trig_field2),
        .mark_en     (mark_en),
        .frame_idx   (frame_idx),
        .marker      (marker_out)
    );
endmodule

// File: tb/tb_ten_field_marker.sv
`timescale 1ns/1ps
module tb_ten_field_marker;
    localparam int B_START = 140;
    localparam int S_HI    = 24;
    localparam int P_HI    = 8;
    localparam int F2_HI   = 16;
    localparam int P_LO    = 8;
    localparam int SCAN    = 300;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       pos_field2 = 1'b0;
    logic [9:0] pos_line = 10'd100;
    logic [9:0] pos_sample = 10'd0;
    logic       mark_en = 1'b0;
    logic       seq_restart = 1'b0;
    logic       marker_out;
    logic [2:0] frame_idx;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    always #4 clk = ~clk;

    ten_field_marker dut (
        .clk         (clk),
        .rst_n       (rst_n),
        .pos_field2  (pos_field2),
        .pos_line    (pos_line),
        .pos_sample  (pos_sample),
        .mark_en     (mark_en),
        .seq_restart (seq_restart),
        .marker_out  (marker_out),
        .frame_idx   (frame_idx)
    );

    // kind: 0 no burst expected, 1 field-1 burst, 2 field-2 burst
    typedef struct packed {
        logic       fs;
        logic       sr;
        logic       en;
        logic       f2;
        logic [9:0] line;
        logic [2:0] idx;
        logic [1:0] kind;
    } vec_t;

    localparam vec_t VECS [0:13] = '{
        '{1'b0, 1'b0, 1'b1, 1'b0, 10'd15,  3'd1, 2'd1},
        '{1'b0, 1'b0, 1'b1, 1'b1, 10'd278, 3'd1, 2'd2},
        '{1'b1, 1'b0, 1'b1, 1'b0, 10'd15,  3'd2, 2'd1},
        '{1'b0, 1'b0, 1'b1, 1'b1, 10'd278, 3'd2, 2'd2},
        '{1'b1, 1'b0, 1'b1, 1'b0, 10'd15,  3'd3, 2'd1},
        '{1'b1, 1'b0, 1'b0, 1'b0, 10'd15,  3'd4, 2'd0},
        '{1'b1, 1'b0, 1'b1, 1'b0, 10'd15,  3'd5, 2'd1},
        '{1'b1, 1'b0, 1'b1, 1'b0, 10'd15,  3'd1, 2'd1},
        '{1'b0, 1'b0, 1'b1, 1'b0, 10'd16,  3'd1, 2'd0},
        '{1'b0, 1'b0, 1'b1, 1'b1, 10'd15,  3'd1, 2'd0},
        '{1'b0, 1'b0, 1'b1, 1'b0, 10'd278, 3'd1, 2'd0},
        '{1'b1, 1'b1, 1'b1, 1'b0, 10'd15,  3'd1, 2'd1},
        '{1'b1, 1'b0, 1'b1, 1'b0, 10'd15,  3'd2, 2'd1},
        '{1'b1, 1'b0, 1'b1, 1'b1, 10'd278, 3'd3, 2'd2}
    };

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    // Expected marker for a burst sample offset (R4, R5, R6).
    function automatic bit exp_mark(input int off, input int kind, input int n);
        int hi, cnt, per, k, r, o;
        if (kind == 0 || off < 0) return 1'b0;
        if (off < S_HI) return 1'b1;
        o = off - (S_HI + P_LO);
        if (o < 0) return 1'b0;
        hi  = (kind == 2) ? F2_HI : P_HI;
        cnt = (kind == 2) ? 1 : n;
        per = hi + P_LO;
        k = o / per;
        r = o % per;
        return (k < cnt) && (r < hi);
    endfunction

    // One frame start sample, optionally with a restart request.
    task automatic frame_start(input bit sr);
        @(negedge clk);
        pos_field2 = 1'b0; pos_line = 10'd1; pos_sample = 10'd0; seq_restart = sr;
        @(negedge clk);
        pos_line = 10'd2; seq_restart = 1'b0;
    endtask

    // Sweep a line contiguously and compare the marker one clock late.
    task automatic scan_line(input bit f2, input int line, input bit en, input int drop_at,
                             input int kind, input int n, input string tag);
        int mis = 0, rises = 0, exp_rises = 0;
        bit prev_m = 1'b0, prev_e = 1'b0;
        for (int s = 0; s <= SCAN + 1; s++) begin
            @(negedge clk);
            if (s > 0) begin
                bit e;
                e = exp_mark(s - 1 - B_START, kind, n);
                if (marker_out !== e) mis++;
                if (marker_out && !prev_m) rises++;
                if (e && !prev_e) exp_rises++;
                prev_m = marker_out;
                prev_e = e;
            end
            if (s <= SCAN) begin
                pos_field2 = f2;
                pos_line   = 10'(line);
                pos_sample = 10'(s);
                mark_en    = en && (drop_at < 0 || s < drop_at);
            end
        end
        pos_line = 10'd100;
        pos_sample = 10'd0;
        n_checks++;
        if (mis != 0) begin
            n_fail++;
            $display("FAIL %s: pulses actual %0d expected %0d, %0d sample mismatches",
                     tag, rises, exp_rises, mis);
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (4) @(negedge clk);
        // R1: reset state
        check(frame_idx == 3'd1, "R1 idx after reset", frame_idx, 1);
        check(marker_out == 1'b0, "R1 marker after reset", marker_out, 0);
        @(negedge clk);
        rst_n = 1'b1;

        for (int i = 0; i < 14; i++) begin
            string mtag;
            if (VECS[i].fs) frame_start(VECS[i].sr);
            check(frame_idx == VECS[i].idx, VECS[i].sr ? "R3 coincident restart" : "R2 frame index",
                  frame_idx, VECS[i].idx);
            case (VECS[i].kind)
                2'd1:    mtag = "R4/R5 field-1 burst";
                2'd2:    mtag = "R6 field-2 burst";
                default: mtag = VECS[i].en ? "R9 non-marker line" : "R7 insertion disabled";
            endcase
            scan_line(VECS[i].f2, int'(VECS[i].line), VECS[i].en, -1,
                      int'(VECS[i].kind), int'(VECS[i].idx), mtag);
        end

        // R3: armed restart waits for the frame start
        @(negedge clk);
        pos_line = 10'd100; pos_sample = 10'd5; seq_restart = 1'b1;
        @(negedge clk);
        seq_restart = 1'b0;
        repeat (3) @(negedge clk);
        check(frame_idx == 3'd3, "R3 held until frame start", frame_idx, 3);
        frame_start(1'b0);
        check(frame_idx == 3'd1, "R3 restart applied", frame_idx, 1);
        frame_start(1'b0);
        check(frame_idx == 3'd2, "R2 advance after restart", frame_idx, 2);

        // R8: enable drops mid-burst, burst still completes
        scan_line(1'b0, 15, 1'b1, B_START + 10, 1, 2, "R8 enable drop mid-burst");

        // R1: reset in the middle of a run
        frame_start(1'b0);
        @(negedge clk);
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        check(frame_idx == 3'd1, "R1 idx after mid-run reset", frame_idx, 1);
        check(marker_out == 1'b0, "R1 marker after mid-run reset", marker_out, 0);
        rst_n = 1'b1;

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end
endmodule